// File: doc/BRIEF.md
# Bitfield Extract and Insert Unit

This block computes the bitfield results of a 64-bit execution stage. It can pull a run of consecutive bits out of a source word, or it can place a run of bits into a word at a chosen position. The other result bits are filled under one of several policies: zeros, copies of the field's top bit, the old destination bits, or sign copies above the field with zeros below it. Each operation is defined by an operation code, a 32/64-bit mode flag, a field start position and a field width.

All seven operations share one datapath. The source is rotated by an amount the control derives from the operation and position, then masked into place. A fill word chosen by the operation is merged in. Illegal field descriptions are flagged, and their result is forced to zero. By default the result is registered, so a valid result appears one cycle after the matching valid input.

Top module: `bitfield_unit`

## Requirements
- R1: With opSel=0 (unsigned extract), the result holds source bits lsb+width-1..lsb at bits width-1..0, and all higher bits are zero. For example, source 0x00AC6874 with lsb=18 and width=7 gives 0x2B.
- R2: With opSel=1 (signed extract), the field is placed as in R1, and every result bit above it, up to the data size, copies the field's top bit. For example, source 0x01AC6874 with lsb=18 and width=7 gives 0xFFFFFFEB in 32-bit mode.
- R3: With opSel=2 (insert), the low width bits of the source replace destination bits lsb+width-1..lsb. Every other destination bit inside the data size is kept.
- R4: With opSel=3 (field clear), destination bits lsb+width-1..lsb become zero and every other destination bit inside the data size is kept. The source has no effect.
- R5: With opSel=4 (unsigned insert into zeros), the low width source bits land at bit lsb, and every other result bit is zero.
- R6: With opSel=5 (signed insert into zeros), the field is placed as in R5. Bits above the field copy the field's top bit, and bits below lsb are zero.
- R7: With opSel=6 (extract then insert low), source bits lsb+width-1..lsb replace destination bits width-1..0. The destination bits above the field are kept.
- R8: width is the plain bit count, 1 to the data size. A width of 0, a width above the data size, lsb+width above the data size, or opSel=7 sets fieldErr to 1 and forces the result to zero.
- R9: wide=1 selects 64-bit mode and wide=0 selects 32-bit mode. In 32-bit mode only bits 31..0 of the source and destination are used, and result bits 63..32 are zero.
- R10: With the output register present (REG_OUT=1), result and fieldErr appear on the first clock edge after the inputs and validOut equals validIn delayed by one cycle. A synchronous active-high rst clears validOut, result and fieldErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| validIn | input | 1 | Operation request valid |
| opSel | input | 3 | Operation code (0..6, 7 reserved) |
| wide | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| srcVal | input | 64 | Source operand |
| dstOld | input | 64 | Previous destination value |
| fieldLsb | input | 6 | Field start bit position |
| fieldWidth | input | 7 | Field width in bits |
| validOut | output | 1 | Result valid |
| result | output | 64 | Result word |
| fieldErr | output | 1 | Illegal field or operation |

## Verification
Several behaviours are checked on every cycle by the assertions. These are the one-cycle valid pipeline and its reset, the zero result on an error, and the zero upper half in 32-bit mode. They also check that unsigned extract leaves nothing above the field, that both insert-into-zeros operations leave nothing below lsb, and that a field clear only ever removes destination bits. Exact field values, sign filling and the preserved destination bits of insert and extract-then-insert depend on data patterns. Only the bench's vectors show those, including full-width fields, fields that touch bit 63 and the error boundaries.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int XLEN  = 64;
  localparam int HALF  = XLEN / 2;
  localparam int LSB_W = $clog2(XLEN);
  localparam int WID_W = LSB_W + 1;
  localparam int SUM_W = WID_W + 1;

  typedef enum logic [2:0] {
    OP_UEXT = 3'd0,
    OP_SEXT = 3'd1,
    OP_INS  = 3'd2,
    OP_CLR  = 3'd3,
    OP_UINZ = 3'd4,
    OP_SINZ = 3'd5,
    OP_XINS = 3'd6,
    OP_RSVD = 3'd7
  } bfu_op_e;

  typedef struct packed {
    logic [LSB_W-1:0] rotAmt;
    logic [XLEN-1:0]  posMask;
    logic [XLEN-1:0]  upperMask;
    logic [XLEN-1:0]  sizeMask;
    logic [LSB_W-1:0] signIdx;
    logic             useSrc;
    logic             keepOld;
    logic             signFill;
    logic             wide;
    logic             err;
  } bfu_ctrl_t;

  function automatic logic [XLEN-1:0] lowMask(input logic [SUM_W-1:0] n);
    if (n >= SUM_W'(XLEN)) return '1;
    return (XLEN'(1) << n) - XLEN'(1);
  endfunction
endpackage

// File: rtl/bfu_ctrl.sv
module bfu_ctrl
  import bfu_pkg::*;
(
  input  logic [2:0]       opSel,
  input  logic             wide,
  input  logic [LSB_W-1:0] fieldLsb,
  input  logic [WID_W-1:0] fieldWidth,
  output bfu_ctrl_t        ctrl
);
  logic [SUM_W-1:0] dataSize;
  logic [SUM_W-1:0] widthExt;
  logic [SUM_W-1:0] fieldSum;
  logic [SUM_W-1:0] fieldEnd;
  logic [XLEN-1:0]  widthMask;
  logic             isExtract;
  bfu_op_e          op;

  always_comb begin
    op        = bfu_op_e'(opSel);
    dataSize  = wide ? SUM_W'(XLEN) : SUM_W'(HALF);
    widthExt  = SUM_W'(fieldWidth);
    fieldSum  = SUM_W'(fieldLsb) + widthExt;
    isExtract = (op == OP_UEXT) || (op == OP_SEXT) || (op == OP_XINS);
    widthMask = lowMask(widthExt);
    fieldEnd  = isExtract ? widthExt : fieldSum;

    ctrl.err = (fieldWidth == '0) || (widthExt > dataSize) ||
               (fieldSum > dataSize) || (op == OP_RSVD);
    ctrl.wide      = wide;
    ctrl.sizeMask  = lowMask(dataSize);
    ctrl.rotAmt    = isExtract ? fieldLsb : LSB_W'(dataSize - SUM_W'(fieldLsb));
    ctrl.posMask   = isExtract ? widthMask : (widthMask << fieldLsb);
    ctrl.upperMask = ctrl.sizeMask & ~lowMask(fieldEnd);
    ctrl.signIdx   = LSB_W'(fieldEnd - SUM_W'(1));
    ctrl.useSrc    = (op != OP_CLR);
    ctrl.keepOld   = (op == OP_INS) || (op == OP_CLR) || (op == OP_XINS);
    ctrl.signFill  = (op == OP_SEXT) || (op == OP_SINZ);
  end
endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath
  import bfu_pkg::*;
(
  input  bfu_ctrl_t       ctrl,
  input  logic [XLEN-1:0] srcVal,
  input  logic [XLEN-1:0] dstOld,
  output logic [XLEN-1:0] resOut,
  output logic            errOut
);
  logic [XLEN-1:0] rotFull;
  logic [HALF-1:0] rotNarrow;
  logic [XLEN-1:0] rotSel;
  logic [XLEN-1:0] fieldBits;
  logic [XLEN-1:0] baseBits;
  logic [XLEN-1:0] fillBits;
  logic            signBit;

  always_comb begin
    rotFull   = XLEN'({srcVal, srcVal} >> ctrl.rotAmt);
    rotNarrow = HALF'({srcVal[HALF-1:0], srcVal[HALF-1:0]} >> ctrl.rotAmt[LSB_W-2:0]);
    rotSel    = ctrl.wide ? rotFull : {{HALF{1'b0}}, rotNarrow};
    signBit   = rotSel[ctrl.signIdx];
    fieldBits = ctrl.useSrc ? (rotSel & ctrl.posMask) : '0;
    baseBits  = ctrl.keepOld ? (dstOld & ~ctrl.posMask) : '0;
    fillBits  = (ctrl.signFill && signBit) ? ctrl.upperMask : '0;
    resOut    = ctrl.err ? '0 : ((fieldBits | baseBits | fillBits) & ctrl.sizeMask);
    errOut    = ctrl.err;
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             validIn,
  input  logic [2:0]       opSel,
  input  logic             wide,
  input  logic [XLEN-1:0]  srcVal,
  input  logic [XLEN-1:0]  dstOld,
  input  logic [LSB_W-1:0] fieldLsb,
  input  logic [WID_W-1:0] fieldWidth,
  output logic             validOut,
  output logic [XLEN-1:0]  result,
  output logic             fieldErr
);
  bfu_ctrl_t       ctrl;
  logic [XLEN-1:0] resComb;
  logic            errComb;

  bfu_ctrl u_ctrl (
    .opSel(opSel), .wide(wide), .fieldLsb(fieldLsb),
    .fieldWidth(fieldWidth), .ctrl(ctrl)
  );

  bfu_datapath u_dp (
    .ctrl(ctrl), .srcVal(srcVal), .dstOld(dstOld),
    .resOut(resComb), .errOut(errComb)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          validOut <= 1'b0;
          result   <= '0;
          fieldErr <= 1'b0;
        end else begin
          validOut <= validIn;
          result   <= resComb;
          fieldErr <= errComb;
        end
      end
    end else begin : g_comb
      assign validOut = validIn;
      assign result   = resComb;
      assign fieldErr = errComb;
    end
  endgenerate
endmodule

// File: rtl/bfu_checker.sv
module bfu_checker
  import bfu_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             validIn,
  input logic [2:0]       opSel,
  input logic             wide,
  input logic [XLEN-1:0]  dstOld,
  input logic [LSB_W-1:0] fieldLsb,
  input logic [WID_W-1:0] fieldWidth,
  input logic             validOut,
  input logic [XLEN-1:0]  result,
  input logic             fieldErr
);
  always_comb begin
    if (!rst && fieldErr === 1'b1)
      assert_errZero_R8: assert (result == '0);
  end

  generate
    if (REG_OUT) begin : g_seq
      assert_resetClears_R10: assert property (@(posedge clk) rst |=> !validOut);
      assert_validFollows_R10: assert property (@(posedge clk) disable iff (rst)
        validIn |=> validOut);
      assert_validDrops_R10: assert property (@(posedge clk) disable iff (rst)
        !validIn |=> !validOut);
      assert_narrowUpper_R9: assert property (@(posedge clk) disable iff (rst)
        !wide |=> result[XLEN-1:HALF] == '0);
      assert_uextHigh_R1: assert property (@(posedge clk) disable iff (rst)
        (opSel == OP_UEXT && fieldWidth < WID_W'(XLEN)) |=> (result >> $past(fieldWidth)) == '0);
      assert_uinzLow_R5: assert property (@(posedge clk) disable iff (rst)
        (opSel == OP_UINZ) |=> ((result >> $past(fieldLsb)) << $past(fieldLsb)) == result);
      assert_sinzLow_R6: assert property (@(posedge clk) disable iff (rst)
        (opSel == OP_SINZ) |=> ((result >> $past(fieldLsb)) << $past(fieldLsb)) == result);
      assert_clearDrops_R4: assert property (@(posedge clk) disable iff (rst)
        (opSel == OP_CLR) |=> (result & ~$past(dstOld)) == '0);
    end
  endgenerate
endmodule

bind bitfield_unit bfu_checker #(.REG_OUT(REG_OUT)) u_bfu_checker (
  .clk(clk), .rst(rst), .validIn(validIn), .opSel(opSel), .wide(wide),
  .dstOld(dstOld), .fieldLsb(fieldLsb), .fieldWidth(fieldWidth),
  .validOut(validOut), .result(result), .fieldErr(fieldErr)
);

// File: tb/test_bitfield_unit.sv
module test_bitfield_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        validIn;
  logic [2:0]  opSel;
  logic        wide;
  logic [63:0] srcVal;
  logic [63:0] dstOld;
  logic [5:0]  fieldLsb;
  logic [6:0]  fieldWidth;
  logic        validOut;
  logic [63:0] result;
  logic        fieldErr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  bitfield_unit i_bitfield_unit (
    .clk(clk), .rst(rst), .validIn(validIn), .opSel(opSel), .wide(wide),
    .srcVal(srcVal), .dstOld(dstOld), .fieldLsb(fieldLsb), .fieldWidth(fieldWidth),
    .validOut(validOut), .result(result), .fieldErr(fieldErr)
  );

  // fields: req(4) op(3) wide(1) lsb(6) width(7) src(64) dst(64) exp(64) err(1)
  localparam int NV = 22;
  localparam logic [213:0] VEC [0:NV-1] = '{
    {4'd1, 3'd0,1'b0,6'd18,7'd7, 64'h00AC6874, 64'h0, 64'h2B, 1'b0},                      // R1
    {4'd2, 3'd1,1'b0,6'd18,7'd7, 64'h01AC6874, 64'h0, 64'hFFFFFFEB, 1'b0},                // R2
    {4'd2, 3'd1,1'b0,6'd18,7'd7, 64'h00AC6874, 64'h0, 64'h2B, 1'b0},                      // R2
    {4'd3, 3'd2,1'b0,6'd9,7'd6, 64'h00AC4E74, 64'hF0F05555, 64'hF0F06955, 1'b0},          // R3
    {4'd4, 3'd3,1'b0,6'd12,7'd4, 64'hFFFFFFFF, 64'h0000ABCD, 64'h00000BCD, 1'b0},         // R4
    {4'd5, 3'd4,1'b0,6'd9,7'd6, 64'h00AC4E74, 64'hF0F05555, 64'h00006800, 1'b0},          // R5
    {4'd6, 3'd5,1'b0,6'd9,7'd6, 64'h00AC4E74, 64'hF0F05555, 64'hFFFFE800, 1'b0},          // R6
    {4'd7, 3'd6,1'b0,6'd25,7'd7, 64'hFE000000, 64'h12345678, 64'h1234567F, 1'b0},         // R7
    {4'd1, 3'd0,1'b1,6'd40,7'd24, 64'hDEADBEEF01234567, 64'h0, 64'h0000000000DEADBE, 1'b0}, // R1
    {4'd2, 3'd1,1'b1,6'd32,7'd32, 64'hDEADBEEF01234567, 64'h0, 64'hFFFFFFFFDEADBEEF, 1'b0}, // R2
    {4'd6, 3'd5,1'b1,6'd60,7'd4, 64'h8, 64'h0, 64'h8000000000000000, 1'b0},               // R6
    {4'd3, 3'd2,1'b1,6'd0,7'd64, 64'h0123456789ABCDEF, 64'hFFFFFFFFFFFFFFFF, 64'h0123456789ABCDEF, 1'b0}, // R3
    {4'd9, 3'd0,1'b0,6'd0,7'd32, 64'hAAAAAAAA12345678, 64'h0, 64'h12345678, 1'b0},        // R9
    {4'd9, 3'd2,1'b0,6'd4,7'd4, 64'h5, 64'hFFFFFFFFFFFFFFFF, 64'h00000000FFFFFF5F, 1'b0},   // R9
    {4'd8, 3'd0,1'b1,6'd0,7'd0, 64'hFFFF, 64'h0, 64'h0, 1'b1},                            // R8
    {4'd8, 3'd0,1'b0,6'd30,7'd3, 64'hFFFFFFFF, 64'h0, 64'h0, 1'b1},                       // R8
    {4'd8, 3'd0,1'b0,6'd0,7'd33, 64'hFFFFFFFF, 64'h0, 64'h0, 1'b1},                       // R8
    {4'd8, 3'd7,1'b1,6'd0,7'd8, 64'hFF, 64'hFF, 64'h0, 1'b1},                             // R8
    {4'd8, 3'd2,1'b1,6'd63,7'd2, 64'h3, 64'hFFFF, 64'h0, 1'b1},                           // R8
    {4'd7, 3'd6,1'b1,6'd56,7'd8, 64'hA500000000000000, 64'h1111111111111111, 64'h11111111111111A5, 1'b0}, // R7
    {4'd5, 3'd4,1'b1,6'd62,7'd2, 64'hF, 64'h1234, 64'hC000000000000000, 1'b0},            // R5
    {4'd4, 3'd3,1'b1,6'd0,7'd64, 64'h0, 64'hFFFF, 64'h0, 1'b0}                             // R4
  };

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [213:0] v, input logic vld);
    validIn    = vld;
    opSel      = v[209:207];
    wide       = v[206];
    fieldLsb   = v[205:200];
    fieldWidth = v[199:193];
    srcVal     = v[192:129];
    dstOld     = v[128:65];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive('0, 1'b0);
    repeat (3) @(negedge clk);
    // R10: reset state
    check64("R10 reset validOut", 64'(validOut), 64'h0);
    check64("R10 reset result", result, 64'h0);
    check64("R10 reset fieldErr", 64'(fieldErr), 64'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i], 1'b1);
      @(negedge clk);
      check64($sformatf("R%0d vec%0d result", VEC[i][213:210], i), result, VEC[i][64:1]);
      check64($sformatf("R%0d vec%0d fieldErr", VEC[i][213:210], i), 64'(fieldErr), 64'(VEC[i][0]));
      check64($sformatf("R10 vec%0d validOut", i), 64'(validOut), 64'h1);
    end

    // R10: validOut tracks validIn one cycle later
    drive(VEC[0], 1'b0);
    @(negedge clk);
    check64("R10 idle validOut", 64'(validOut), 64'h0);
    check64("R1 idle result", result, 64'h2B);
    drive(VEC[1], 1'b1);
    @(negedge clk);
    check64("R10 single validOut", 64'(validOut), 64'h1);
    check64("R2 single result", result, 64'hFFFFFFEB);
    validIn = 1'b0;
    @(negedge clk);
    check64("R10 drop validOut", 64'(validOut), 64'h0);

    // R4: source has no effect on clear
    drive({4'd4, 3'd3,1'b1,6'd8,7'd8, 64'hFFFFFFFFFFFFFFFF, 64'h0F0F0F0F0F0F0F0F, 64'h0, 1'b0}, 1'b1);
    @(negedge clk);
    check64("R4 clear with full source", result, 64'h0F0F0F0F0F0F000F);
    drive({4'd4, 3'd3,1'b1,6'd8,7'd8, 64'h0, 64'h0F0F0F0F0F0F0F0F, 64'h0, 1'b0}, 1'b1);
    @(negedge clk);
    check64("R4 clear with zero source", result, 64'h0F0F0F0F0F0F000F);

    // R6: sign field positive gives zero above
    drive({4'd6, 3'd5,1'b1,6'd4,7'd4, 64'h7, 64'hFFFF, 64'h0, 1'b0}, 1'b1);
    @(negedge clk);
    check64("R6 positive field", result, 64'h70);

    // R10: synchronous reset while valid
    drive(VEC[3], 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check64("R10 reset mid-run validOut", 64'(validOut), 64'h0);
    check64("R10 reset mid-run result", result, 64'h0);
    rst = 1'b0;
    validIn = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule